// File: doc/BRIEF.md
# Authenticated Configuration Stream Controller

This block takes a configuration image delivered as a stream of 128-bit blocks. Each block carries a kind code. The block checks the whole image against a cipher-based message authentication code (CMAC) and, in the same pass, recovers the encrypted body with a counter-mode keystream. Recovered body words are written to a configuration-memory port at consecutive addresses. When the tag block arrives, the block closes the CMAC and compares the result with the received tag. A match releases the boot blocks that follow. A mismatch issues a memory clear and shuts the stream out.

Both cipher uses need only the forward direction of a 128-bit block cipher. That function sits outside the block, behind a request/acknowledge port, so a single cipher instance serves subkey derivation, keystream generation and tag chaining in turn. Authentication and decryption use two separate key inputs. When authentication is switched off, the tag is computed under an all-zero key and serves as an integrity checksum. A mode input chooses whether the tag covers the recovered plaintext or the received ciphertext of the body.

Top module: `acfg_ctrl`

## Requirements
- R1: After reset, `busy` is 1 and `done`, `pass`, `mem_we`, `mem_clr` and `boot_valid` are 0. The first cipher request encrypts the all-zero block under the effective authentication key, to derive subkeys.
- R2: Kind codes on `in_kind` are: 0 header, 1 body, 2 footer, 3 tag, 4 boot. Header and footer blocks enter the tag computation unchanged and produce no memory write.
- R3: A body block C is written to memory as C XOR E(dec_key, ctr), at addresses 0, 1, 2, … in arrival order. `ctr` is loaded from the data of the first header block after reset and steps by one after each body block. Later header blocks do not reload it.
- R4: The tag is a CMAC over the authenticated items in arrival order. The subkeys are K1 = dbl(E(k, 0)) and K2 = dbl(K1), where dbl shifts left one bit and XORs 0x87 into the low byte when the dropped bit was 1. The last item is XORed with K1. An empty message uses the block 1 followed by 127 zeros, XORed with K2.
- R5: With `mac_first` = 1 the tag covers the plaintext body blocks. With `mac_first` = 0 it covers the ciphertext body blocks.
- R6: With `auth_en` = 0 the CMAC key is all zeros, whatever `auth_key` holds.
- R7: After a tag block is accepted, `done` pulses for exactly one cycle. `pass` then holds 1 if the computed tag equals the received tag and 0 otherwise, until reset.
- R8: On a mismatch, `mem_clr` pulses once, in the same cycle as `done`. It never pulses on a match.
- R9: After a match, each accepted boot block appears on `boot_data` with `boot_valid` high for one cycle, in the following cycle. After a mismatch, and before the tag block, boot blocks are consumed with no output.
- R10: After `done`, header, body, footer and tag blocks are accepted and ignored. They cause no memory write, no cipher request and no further `done`, and `pass` does not change. `busy` is 0 from `done` onward.
- R11: `ciph_req` stays high with `ciph_key` and `ciph_din` stable until `ciph_ack`. `dec_key` is used only for keystream requests and the effective authentication key for all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auth_en | input | 1 | 1: authenticate with `auth_key`; 0: zero key (checksum use) |
| mac_first | input | 1 | 1: tag over plaintext body; 0: tag over ciphertext body |
| auth_key | input | 128 | CMAC key |
| dec_key | input | 128 | Counter-mode key |
| in_valid | input | 1 | Stream block present |
| in_kind | input | 3 | Block kind code |
| in_data | input | 128 | Block payload |
| in_ready | output | 1 | Block accepted on this edge when `in_valid` is high |
| ciph_req | output | 1 | Cipher request |
| ciph_key | output | 128 | Key for the request |
| ciph_din | output | 128 | Block to encrypt |
| ciph_ack | input | 1 | One-cycle completion strobe |
| ciph_dout | input | 128 | Encrypted block, valid with `ciph_ack` |
| mem_we | output | 1 | Configuration-memory write strobe |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | 128 | Recovered body block |
| mem_clr | output | 1 | Clear-memory pulse on authentication failure |
| boot_valid | output | 1 | Released boot block strobe |
| boot_data | output | 128 | Released boot block |
| done | output | 1 | Tag comparison finished (one-cycle pulse) |
| pass | output | 1 | Tag matched |
| busy | output | 1 | Configuration still in progress |

## Verification
The assertions take for granted that the cipher responder raises `ciph_ack` only while `ciph_req` is high, for a single cycle, with its result on `ciph_dout`. They also assume both keys and the two mode inputs stay constant between reset and `done`. The bench's cipher model answers each request once after a fixed delay, and holds `ciph_ack` low in every other cycle. Mode and key inputs change only while reset is asserted. Stream blocks are presented at falling edges and held until `in_ready` has been seen high, so every accepted block is taken on exactly one rising edge.

// File: rtl/acfg_pkg.sv
// Shared types and helpers for the authenticated configuration controller.
// Assumes a 128-bit block cipher (the CMAC reduction constant is 0x87).
package acfg_pkg;

    localparam int BLK_W = 128;

    // Stream block kinds; the code values are part of the external contract.
    typedef enum logic [2:0] {
        KIND_HDR  = 3'd0,
        KIND_BODY = 3'd1,
        KIND_FTR  = 3'd2,
        KIND_TAG  = 3'd3,
        KIND_BOOT = 3'd4
    } blk_kind_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_SUBKEY,
        ST_IDLE,
        ST_KSTREAM,
        ST_ABSORB,
        ST_FINAL,
        ST_DONE
    } seq_st_e;

    // Padding block for an empty CMAC message: a single 1 then zeros.
    localparam logic [BLK_W-1:0] PAD_EMPTY = {1'b1, {(BLK_W-1){1'b0}}};

    // Multiply by x in GF(2^128) for subkey derivation.
    function automatic logic [BLK_W-1:0] gf_dbl(input logic [BLK_W-1:0] v);
        return {v[BLK_W-2:0], 1'b0} ^ (v[BLK_W-1] ? BLK_W'(8'h87) : '0);
    endfunction

endpackage

// File: rtl/acfg_subkeys.sv
// Holds the two CMAC subkeys derived from L = E(k, 0).
// Assumes load is pulsed once, when the subkey cipher result arrives.
module acfg_subkeys
    import acfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BLK_W-1:0] l_val,
    output logic [BLK_W-1:0] k1,
    output logic [BLK_W-1:0] k2
);

    logic [BLK_W-1:0] k1_next;

    assign k1_next = gf_dbl(l_val);

    // Capture both subkeys from the zero-block encryption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k1 <= '0;
            k2 <= '0;
        end else if (load) begin
            k1 <= k1_next;
            k2 <= gf_dbl(k1_next);
        end
    end

endmodule

// File: rtl/acfg_ctr.sv
// Counter-mode block counter: loaded once from the header, stepped per body block.
// Assumes load and inc are never high together.
module acfg_ctr #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] value
);

    // Load the initial count or advance by one.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (inc)  value <= value + W'(1);
    end

endmodule

// File: rtl/acfg_wrport.sv
// Registered configuration-memory write port with an auto-incrementing address.
// Assumes one write request per recovered body block; the address starts at zero.
module acfg_wrport
    import acfg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BLK_W-1:0]  wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_data
);

    logic [ADDR_W-1:0] next_addr;

    // Register the write and advance the address after each one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
            next_addr <= '0;
        end else begin
            mem_we <= wr;
            if (wr) begin
                mem_addr  <= next_addr;
                mem_data  <= wdata;
                next_addr <= next_addr + ADDR_W'(1);
            end
        end
    end

endmodule

// File: rtl/acfg_ctrl.sv
// Authenticated configuration controller: a CMAC over header, body and footer blocks,
// counter-mode decryption of the body, a tag check, then boot release or memory clear.
// The last authenticated item is held back one block, so the tag block itself marks
// where the message ends. Assumes keys and modes are stable from reset to done, and
// that the external forward cipher acknowledges each request once, for one cycle.
module acfg_ctrl
    import acfg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auth_en,
    input  logic              mac_first,
    input  logic [BLK_W-1:0]  auth_key,
    input  logic [BLK_W-1:0]  dec_key,
    input  logic              in_valid,
    input  logic [2:0]        in_kind,
    input  logic [BLK_W-1:0]  in_data,
    output logic              in_ready,
    output logic              ciph_req,
    output logic [BLK_W-1:0]  ciph_key,
    output logic [BLK_W-1:0]  ciph_din,
    input  logic              ciph_ack,
    input  logic [BLK_W-1:0]  ciph_dout,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_data,
    output logic              mem_clr,
    output logic              boot_valid,
    output logic [BLK_W-1:0]  boot_data,
    output logic              done,
    output logic              pass,
    output logic              busy
);

    seq_st_e          state;
    blk_kind_e        kind;
    logic [BLK_W-1:0] akey_eff;
    logic [BLK_W-1:0] chain_q;
    logic [BLK_W-1:0] pend_q;
    logic             pend_v;
    logic [BLK_W-1:0] item_q;
    logic [BLK_W-1:0] tag_q;
    logic             hdr_seen;
    logic [BLK_W-1:0] k1, k2;
    logic [BLK_W-1:0] ctr_val;
    logic             ctr_load, ctr_inc;
    logic [BLK_W-1:0] plain;
    logic [BLK_W-1:0] body_item;
    logic             accept;

    assign kind      = blk_kind_e'(in_kind);
    assign akey_eff  = auth_en ? auth_key : '0;
    assign in_ready  = (state == ST_IDLE) || (state == ST_DONE);
    assign accept    = in_valid && in_ready;
    assign busy      = (state != ST_DONE);
    assign plain     = item_q ^ ciph_dout;
    assign body_item = mac_first ? plain : item_q;
    assign ctr_load  = accept && (state == ST_IDLE) && (kind == KIND_HDR) && !hdr_seen;
    assign ctr_inc   = (state == ST_KSTREAM) && ciph_ack;

    acfg_subkeys u_subkeys (
        .clk   (clk),
        .rst_n (rst_n),
        .load  ((state == ST_SUBKEY) && ciph_ack),
        .l_val (ciph_dout),
        .k1    (k1),
        .k2    (k2)
    );

    acfg_ctr #(.W(BLK_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (in_data),
        .inc      (ctr_inc),
        .value    (ctr_val)
    );

    acfg_wrport #(.ADDR_W(ADDR_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctr_inc),
        .wdata    (plain),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_data (mem_data)
    );

    // Drive the shared cipher request from the current state.
    always_comb begin
        ciph_req = 1'b0;
        ciph_key = akey_eff;
        ciph_din = '0;
        unique case (state)
            ST_SUBKEY: ciph_req = 1'b1;
            ST_KSTREAM: begin
                ciph_req = 1'b1;
                ciph_key = dec_key;
                ciph_din = ctr_val;
            end
            ST_ABSORB: begin
                ciph_req = 1'b1;
                ciph_din = chain_q ^ pend_q;
            end
            ST_FINAL: begin
                ciph_req = 1'b1;
                ciph_din = pend_v ? (chain_q ^ pend_q ^ k1) : (chain_q ^ PAD_EMPTY ^ k2);
            end
            default: ;
        endcase
    end

    // Sequence the stream: absorb, decrypt, finalise, then release boot data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_SUBKEY;
            chain_q    <= '0;
            pend_q     <= '0;
            pend_v     <= 1'b0;
            item_q     <= '0;
            tag_q      <= '0;
            hdr_seen   <= 1'b0;
            pass       <= 1'b0;
            done       <= 1'b0;
            mem_clr    <= 1'b0;
            boot_valid <= 1'b0;
            boot_data  <= '0;
        end else begin
            done       <= 1'b0;
            mem_clr    <= 1'b0;
            boot_valid <= 1'b0;
            unique case (state)
                ST_SUBKEY: if (ciph_ack) state <= ST_IDLE;
                ST_IDLE: if (in_valid) begin
                    case (kind)
                        KIND_HDR, KIND_FTR: begin
                            if (kind == KIND_HDR) hdr_seen <= 1'b1;
                            item_q <= in_data;
                            if (pend_v) state <= ST_ABSORB;
                            else begin
                                pend_q <= in_data;
                                pend_v <= 1'b1;
                            end
                        end
                        KIND_BODY: begin
                            item_q <= in_data;
                            state  <= ST_KSTREAM;
                        end
                        KIND_TAG: begin
                            tag_q <= in_data;
                            state <= ST_FINAL;
                        end
                        default: ;
                    endcase
                end
                ST_KSTREAM: if (ciph_ack) begin
                    if (pend_v) begin
                        item_q <= body_item;
                        state  <= ST_ABSORB;
                    end else begin
                        pend_q <= body_item;
                        pend_v <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_ABSORB: if (ciph_ack) begin
                    chain_q <= ciph_dout;
                    pend_q  <= item_q;
                    state   <= ST_IDLE;
                end
                ST_FINAL: if (ciph_ack) begin
                    done    <= 1'b1;
                    pass    <= (ciph_dout == tag_q);
                    mem_clr <= (ciph_dout != tag_q);
                    state   <= ST_DONE;
                end
                ST_DONE: if (in_valid && (kind == KIND_BOOT) && pass) begin
                    boot_valid <= 1'b1;
                    boot_data  <= in_data;
                end
                default: state <= ST_SUBKEY;
            endcase
        end
    end

    // R11: a request is held, with key and data steady, until acknowledged.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ciph_req && !ciph_ack |=> ciph_req && $stable(ciph_din) && $stable(ciph_key));

    // R11: an acknowledge only ever answers an open request (input contract).
    p_ack_in_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ciph_ack |-> ciph_req);

    // R7: the completion strobe lasts one cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a memory clear only accompanies a failed comparison.
    p_clr_on_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clr |-> done && !pass);

    // R9: boot data is released only after a successful check.
    p_boot_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        boot_valid |-> pass && !busy);

    // R10: once finished, no writes and no cipher traffic.
    p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we && !ciph_req);

endmodule

// File: tb/acfg_ctrl_tb.sv
// Scoreboard bench: driver tasks queue expected writes and boot blocks,
// a monitor process pops and compares them as the design emits them.
module acfg_ctrl_tb_top;

    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              auth_en = 1'b0, mac_first = 1'b0;
    logic [127:0]      auth_key = '0, dec_key = '0;
    logic              in_valid = 1'b0;
    logic [2:0]        in_kind = '0;
    logic [127:0]      in_data = '0;
    logic              in_ready;
    logic              ciph_req;
    logic [127:0]      ciph_key, ciph_din;
    logic              ciph_ack;
    logic [127:0]      ciph_dout;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [127:0]      mem_data;
    logic              mem_clr, boot_valid, done, pass, busy;
    logic [127:0]      boot_data;

    always #4 clk = ~clk;

    acfg_ctrl #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .auth_en(auth_en), .mac_first(mac_first),
        .auth_key(auth_key), .dec_key(dec_key), .in_valid(in_valid),
        .in_kind(in_kind), .in_data(in_data), .in_ready(in_ready),
        .ciph_req(ciph_req), .ciph_key(ciph_key), .ciph_din(ciph_din),
        .ciph_ack(ciph_ack), .ciph_dout(ciph_dout), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_clr(mem_clr),
        .boot_valid(boot_valid), .boot_data(boot_data), .done(done),
        .pass(pass), .busy(busy)
    );

    // Keyed permutation standing in for the forward block cipher.
    function automatic logic [127:0] perm(input logic [127:0] k, input logic [127:0] x);
        logic [127:0] t;
        t = x ^ k;
        for (int r = 0; r < 4; r++) begin
            t = {t[94:0], t[127:95]} + (k ^ 128'(r + 1));
            t = t ^ (t >> 17);
        end
        return t;
    endfunction

    function automatic logic [127:0] dbl(input logic [127:0] v);
        logic [127:0] s;
        s = v << 1;
        if (v[127]) s[7:0] = s[7:0] ^ 8'h87;
        return s;
    endfunction

    function automatic logic [127:0] blk(input int i);
        return {32'hA5A5_0000 + i, ~i, i * 7, 32'h1234_5678 ^ i};
    endfunction

    // Cipher responder: answers each request after a fixed delay.
    logic         ack_r = 1'b0;
    logic [127:0] dout_r = '0;
    int           wait_c = 0;
    int           ack_cnt = 0;
    logic         got_first = 1'b0;
    logic [127:0] first_key = '0, first_din = '0;
    assign ciph_ack  = ack_r;
    assign ciph_dout = dout_r;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_r <= 1'b0; wait_c <= 0; ack_cnt <= 0; got_first <= 1'b0;
        end else begin
            if (ciph_req && !got_first) begin
                got_first <= 1'b1; first_key <= ciph_key; first_din <= ciph_din;
            end
            if (ack_r) begin
                ack_r <= 1'b0; wait_c <= 0; ack_cnt <= ack_cnt + 1;
            end else if (ciph_req) begin
                if (wait_c == 2) begin
                    ack_r <= 1'b1; dout_r <= perm(ciph_key, ciph_din);
                end else wait_c <= wait_c + 1;
            end
        end
    end

    // Scoreboard queues.
    typedef struct packed { logic [ADDR_W-1:0] a; logic [127:0] d; } wr_t;
    wr_t          exp_wr[$];
    logic [127:0] exp_boot[$];

    int n_chk = 0, n_fail = 0;
    int m_chk = 0, m_fail = 0;
    int done_cnt = 0, clr_cnt = 0;

    // Monitor: compares writes and boot blocks, tallies done and clear pulses.
    always @(negedge clk) begin
        if (!rst_n) begin
            done_cnt <= 0; clr_cnt <= 0;
        end else begin
            if (mem_we) begin
                m_chk++;
                if (exp_wr.size() == 0) begin
                    m_fail++;
                    $display("FAIL R3/R10 unexpected write addr=%0d data=%h expected none", mem_addr, mem_data);
                end else begin
                    wr_t e;
                    e = exp_wr.pop_front();
                    if (e.a != mem_addr || e.d != mem_data) begin
                        m_fail++;
                        $display("FAIL R3 write addr=%0d data=%h expected addr=%0d data=%h",
                                 mem_addr, mem_data, e.a, e.d);
                    end
                end
            end
            if (boot_valid) begin
                m_chk++;
                if (exp_boot.size() == 0) begin
                    m_fail++;
                    $display("FAIL R9 unexpected boot data=%h expected none", boot_data);
                end else begin
                    logic [127:0] eb;
                    eb = exp_boot.pop_front();
                    if (eb != boot_data) begin
                        m_fail++;
                        $display("FAIL R9 boot data=%h expected %h", boot_data, eb);
                    end
                end
            end
            if (done) done_cnt <= done_cnt + 1;
            if (mem_clr) begin
                clr_cnt <= clr_cnt + 1;
                if (!done) begin
                    m_fail++;
                    $display("FAIL R8 clear without done act=0 exp=1");
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [2:0] k, input logic [127:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_data = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [127:0] cmac(input logic [127:0] k, input logic [127:0] m[$]);
        logic [127:0] l, s1, s2, x;
        l = perm(k, '0); s1 = dbl(l); s2 = dbl(s1);
        if (m.size() == 0) return perm(k, {1'b1, 127'b0} ^ s2);
        x = '0;
        for (int i = 0; i < m.size() - 1; i++) x = perm(k, x ^ m[i]);
        return perm(k, x ^ m[m.size() - 1] ^ s1);
    endfunction

    task automatic wait_done();
        for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
    endtask

    // One full configuration; tmode 0: correct tag, 1: flipped bit, 2: tag for the other body mode.
    task automatic run_cfg(input string nm, input logic [127:0] ak, input logic [127:0] dk,
                           input logic en, input logic mf, input int nh, input int nb,
                           input int nf, input int tmode, input int nboot, input int seed);
        logic [127:0] msg[$];
        logic [127:0] alt[$];
        logic [127:0] ctr, d, ks, pt, tag;
        bit expect_pass;
        auth_key = ak; dec_key = dk; auth_en = en; mac_first = mf;
        do_reset();
        ctr = '0;
        for (int i = 0; i < nh; i++) begin
            d = blk(seed + i);
            if (i == 0) ctr = d;
            msg.push_back(d); alt.push_back(d);
            send(3'd0, d);
        end
        send(3'd4, blk(seed + 90));  // boot block before the tag: consumed silently (R9)
        for (int i = 0; i < nb; i++) begin
            d = blk(seed + 20 + i);
            ks = perm(dk, ctr); pt = d ^ ks; ctr = ctr + 1;
            exp_wr.push_back('{a: ADDR_W'(i), d: pt});
            msg.push_back(mf ? pt : d); alt.push_back(mf ? d : pt);
            send(3'd1, d);
        end
        for (int i = 0; i < nf; i++) begin
            d = blk(seed + 40 + i);
            msg.push_back(d); alt.push_back(d);
            send(3'd2, d);
        end
        tag = (tmode == 2) ? cmac(en ? ak : '0, alt) : cmac(en ? ak : '0, msg);
        if (tmode == 1) tag[5] = ~tag[5];
        expect_pass = (tmode == 0);
        send(3'd3, tag);
        wait_done();
        @(negedge clk);
        chk(done_cnt == 1, {"R7 done pulse count ", nm}, 128'(done_cnt), 128'd1);
        chk(pass == expect_pass, {"R4/R5/R6/R7 pass flag ", nm}, 128'(pass), 128'(expect_pass));
        chk(clr_cnt == (expect_pass ? 0 : 1), {"R8 clear count ", nm}, 128'(clr_cnt),
            128'(expect_pass ? 0 : 1));
        chk(busy == 1'b0, {"R10 busy after done ", nm}, 128'(busy), 128'd0);
        for (int i = 0; i < nboot; i++) begin
            d = blk(seed + 70 + i);
            if (expect_pass) exp_boot.push_back(d);
            send(3'd4, d);
        end
        repeat (3) @(negedge clk);
        chk(exp_wr.size() == 0, {"R3 pending writes ", nm}, 128'(exp_wr.size()), 128'd0);
        chk(exp_boot.size() == 0, {"R9 pending boot ", nm}, 128'(exp_boot.size()), 128'd0);
    endtask

    bit finished = 1'b0;

    initial begin
        int acks_before;
        // R1: reset state and the subkey request.
        auth_key = 128'hDEAD; auth_en = 1'b1;
        do_reset();
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy after reset", 128'(busy), 128'd1);
        chk(!done && !pass && !mem_we && !mem_clr && !boot_valid, "R1 outputs quiet after reset",
            {123'b0, done, pass, mem_we, mem_clr, boot_valid}, 128'd0);
        repeat (6) @(negedge clk);
        chk(first_din == '0, "R1 first request is zero block", first_din, '0);
        chk(first_key == 128'hDEAD, "R1 first request uses auth key", first_key, 128'hDEAD);

        // R2 R3 R4 R5 R9: plaintext-covering tag, two headers (second must not reload the counter).
        run_cfg("mac_first pass", 128'h0F1E_2D3C, 128'h7777_AAAA_5555, 1'b1, 1'b1, 2, 3, 1, 0, 2, 1);
        // R8 R9: tampered tag.
        run_cfg("tampered tag", 128'h0F1E_2D3C, 128'h7777_AAAA_5555, 1'b1, 1'b1, 1, 2, 2, 1, 2, 11);
        // R5: ciphertext-covering tag.
        run_cfg("enc_first pass", 128'h1357_9BDF, 128'h2468_ACE0, 1'b1, 1'b0, 1, 4, 1, 0, 1, 21);
        // R5: tag computed for the other mode must fail.
        run_cfg("wrong mode tag", 128'h1357_9BDF, 128'h2468_ACE0, 1'b1, 1'b0, 1, 2, 1, 2, 1, 31);
        // R6: authentication off, zero key.
        run_cfg("zero key", 128'hFFFF_0000_1111, 128'h9999, 1'b0, 1'b1, 1, 2, 1, 0, 1, 41);
        // R4: empty message takes the second subkey path.
        run_cfg("empty message", 128'hABCD_EF01, 128'h4242, 1'b1, 1'b1, 0, 0, 0, 0, 1, 51);
        // R2: single footer only (held-back item uses the first subkey).
        run_cfg("footer only", 128'hABCD_EF01, 128'h4242, 1'b1, 1'b0, 0, 0, 1, 0, 0, 61);

        // R10: blocks after done are ignored.
        acks_before = ack_cnt;
        send(3'd0, blk(500));
        send(3'd1, blk(501));
        send(3'd3, blk(502));
        repeat (10) @(negedge clk);
        chk(done_cnt == 1, "R10 no second done", 128'(done_cnt), 128'd1);
        chk(pass == 1'b1, "R10 pass unchanged", 128'(pass), 128'd1);
        chk(ack_cnt == acks_before, "R10 no cipher traffic", 128'(ack_cnt), 128'(acks_before));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_fail + m_fail);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk + m_chk + 1, n_fail + m_fail + 1);
            $finish;
        end
    end

endmodule